// File: doc/BRIEF.md
# Dual Transmit Buffer Controller

This block is a memory-mapped transmit engine with two frame buffers. Software fills one buffer, writes its byte count, and sets the start bit in that buffer's control/status word. While that buffer drains, software can fill the other one. The engine reads the frame bytes out of a shared on-chip RAM and presents them one per clock on a byte stream with a valid flag and an end-of-frame flag. When a buffer has been consumed, its start bit clears and an optional one-cycle interrupt pulse fires.

A second command uses the same buffer in a different way. Software sets the start bit and the load bit together. The engine then copies the first six bytes of the buffer into a 48-bit station address register and sends no frame. The block includes the buffer RAM, the register decode on a plain 32-bit bus with single-cycle read latency, the transmit sequencer and the completion pulse. Framing, checksums and the line interface belong to other blocks.

Top module: `dual_txbuf`

## Requirements
- R1: Address bit 11 selects the buffer (0 or 1). Within a buffer, byte offsets 0x000 to 0x7F0 are frame data words. 0x7F4 is the byte count, whose low 16 bits are stored and read back zero-extended. 0x7FC is the control/status word. 0x7F8 reads as 0 and ignores writes. Read data appears on `bus_rdata` in the cycle after the read request.
- R2: In the control/status word, bit 0 is start/busy, bit 1 is load-address, bit 3 is interrupt enable and bit 31 is a software marker. Bits 3 and 31 are stored from every control write and read back. The marker never changes the stream, the interrupt or the station address. All other bits read 0.
- R3: A control write with bit 0 = 1 and bit 1 = 0 to an idle buffer sends `count` bytes. Byte n comes from data word n/4, bits [8*(n%4)+7 : 8*(n%4)]. `tx_valid` stays high on every cycle from the first byte to the last, and `tx_last` is high only with the final byte.
- R4: The busy bit stays 1 while the frame is being sent. It reads 0 after the clock edge that presents the final byte.
- R5: A control write with bits 0 and 1 both set to an idle buffer loads bytes 0 to 5 of that buffer into `station_addr`, with byte 0 in bits [47:40] and byte 5 in bits [7:0]. No byte is streamed, and bits 0 and 1 then read 0.
- R6: When a send or an address load completes and bit 3 is set, `tx_irq` is high for exactly one cycle. For a frame, that cycle is the same one in which `tx_last` is high. Completion with bit 3 clear gives no pulse.
- R7: When both buffers have been started, frames go out in the order their start bits were written.
- R8: A control write with bit 0 = 0 cancels that buffer. Busy and load-address clear at once. A frame in progress stops with no `tx_last` and no interrupt. A buffer still waiting to be sent is never sent. The next start on that buffer works normally.
- R9: A send with a byte count of 0 streams nothing and completes: busy clears and the interrupt rule of R6 applies.
- R10: A control write with bit 0 = 1 to a buffer that is already busy neither restarts it nor changes its load-address bit. It does update bits 3 and 31.
- R11: After reset, all control words and byte counts read 0, and `tx_valid`, `tx_last`, `tx_irq` and `station_addr` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Bus access request this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address, bit 11 selects the buffer |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after the request |
| tx_data | output | 8 | Streamed frame byte |
| tx_valid | output | 1 | `tx_data` holds a frame byte |
| tx_last | output | 1 | Final byte of the frame |
| tx_irq | output | 1 | One-cycle completion pulse |
| station_addr | output | 48 | Station address loaded by the load command |

## Verification
On every cycle, the assertions check the following. The end-of-frame flag never appears without valid data. The stream is silent after an idle engine cycle. An interrupt pulse lasts one cycle and always follows a completion. A cancel of the active buffer returns the engine to idle. The load-address bit is never set without busy. A completion only ever retires a busy buffer. The station address changes only on a completion. Only the bench's scenarios can show that the right bytes come out in the right order, that interrupts line up with the final byte, that frames go out in start order, that a cancelled buffer stays silent, and that the marker bit has no effect. The bench sweeps frame lengths over both buffers and lane offsets, and computes the expected bytes and address from its own data pattern.

// File: rtl/txb_pkg.sv
package txb_pkg;
  typedef enum logic [1:0] {ENG_IDLE, ENG_RUN, ENG_WAIT} eng_state_t;
  localparam int unsigned STATION_BYTES = 6;
  localparam int unsigned NUM_BUFS      = 2;
endpackage

// File: rtl/txb_ram.sv
module txb_ram #(
  parameter int unsigned AW = 10,
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          a_we,
  input  logic [AW-1:0] a_addr,
  input  logic [DW-1:0] a_wdata,
  output logic [DW-1:0] a_rdata,
  input  logic [AW-1:0] b_addr,
  output logic [DW-1:0] b_rdata
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  // port A: bus side, read-first
  always_ff @(posedge clk) begin
    if (a_we) mem[a_addr] <= a_wdata;
    a_rdata <= mem[a_addr];
  end

  // port B: transmit sequencer, read only
  always_ff @(posedge clk) begin
    b_rdata <= mem[b_addr];
  end
endmodule

// File: rtl/txb_regs.sv
module txb_regs
  import txb_pkg::*;
#(
  parameter int unsigned BUF_AW = 11,
  parameter int unsigned LEN_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [BUF_AW:0]   bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              ram_we,
  output logic [BUF_AW-2:0] ram_addr,
  input  logic [31:0]       ram_rdata,
  output logic [1:0]        busy_o,
  output logic [1:0]        prog_o,
  output logic [1:0]        ie_o,
  output logic [1:0]        cancel_o,
  output logic [LEN_W-1:0]  len_o [NUM_BUFS],
  input  logic [1:0]        done_i
);
  localparam logic [BUF_AW-1:0] LEN_OFF  = BUF_AW'((1 << BUF_AW) - 12);
  localparam logic [BUF_AW-1:0] STAT_OFF = BUF_AW'((1 << BUF_AW) - 4);

  logic [BUF_AW-1:0] off;
  logic              data_hit;
  logic [31:0]       stat_w [NUM_BUFS];
  logic [31:0]       reg_mux;
  logic [31:0]       rd_reg_q;
  logic              rd_ram_q;

  assign off      = bus_addr[BUF_AW-1:0];
  assign data_hit = off < LEN_OFF;
  assign ram_we   = bus_sel & bus_we & data_hit;
  assign ram_addr = {bus_addr[BUF_AW], bus_addr[BUF_AW-1:2]};

  for (genvar b = 0; b < NUM_BUFS; b++) begin : g_buf
    logic             sel_w;
    logic             busy_r, prog_r, ie_r, mark_r;
    logic [LEN_W-1:0] len_r;

    assign sel_w = bus_sel & bus_we & (bus_addr[BUF_AW] == 1'(b));
    assign cancel_o[b] = sel_w & (off == STAT_OFF) & ~bus_wdata[0];

    always_ff @(posedge clk) begin
      if (rst) begin
        busy_r <= 1'b0;
        prog_r <= 1'b0;
        ie_r   <= 1'b0;
        mark_r <= 1'b0;
        len_r  <= '0;
      end else begin
        if (done_i[b]) begin
          busy_r <= 1'b0;
          prog_r <= 1'b0;
        end
        if (sel_w && off == STAT_OFF) begin
          ie_r   <= bus_wdata[3];
          mark_r <= bus_wdata[31];
          if (!bus_wdata[0]) begin
            busy_r <= 1'b0;
            prog_r <= 1'b0;
          end else if (!busy_r) begin
            busy_r <= 1'b1;
            prog_r <= bus_wdata[1];
          end
        end
        if (sel_w && off == LEN_OFF) len_r <= bus_wdata[LEN_W-1:0];
      end
    end

    assign busy_o[b] = busy_r;
    assign prog_o[b] = prog_r;
    assign ie_o[b]   = ie_r;
    assign len_o[b]  = len_r;
    assign stat_w[b] = {mark_r, 27'b0, ie_r, 1'b0, prog_r, busy_r};

    // R5: the load command only exists as part of a busy buffer
    p_prog_needs_busy_r5: assert property (@(posedge clk) disable iff (rst)
      prog_r |-> busy_r);
    // R4: the sequencer only retires a buffer that is busy
    p_done_hits_busy_r4: assert property (@(posedge clk) disable iff (rst)
      done_i[b] |-> busy_r);
  end

  always_comb begin
    reg_mux = '0;
    if (off == STAT_OFF) reg_mux = stat_w[bus_addr[BUF_AW]];
    else if (off == LEN_OFF) reg_mux = {{(32-LEN_W){1'b0}}, len_o[bus_addr[BUF_AW]]};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_ram_q <= 1'b0;
      rd_reg_q <= '0;
    end else begin
      rd_ram_q <= bus_sel & ~bus_we & data_hit;
      rd_reg_q <= reg_mux;
    end
  end

  assign bus_rdata = rd_ram_q ? ram_rdata : rd_reg_q;
endmodule

// File: rtl/txb_engine.sv
module txb_engine
  import txb_pkg::*;
#(
  parameter int unsigned BUF_AW = 11,
  parameter int unsigned LEN_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        busy_i,
  input  logic [1:0]        prog_i,
  input  logic [1:0]        ie_i,
  input  logic [1:0]        cancel_i,
  input  logic [LEN_W-1:0]  len_i [NUM_BUFS],
  output logic [1:0]        done_o,
  output logic [BUF_AW-2:0] ram_addr,
  input  logic [31:0]       ram_rdata,
  output logic [7:0]        tx_data,
  output logic              tx_valid,
  output logic              tx_last,
  output logic              tx_irq,
  output logic [47:0]       station_addr
);
  eng_state_t       st;
  logic             act, act_prog;
  logic [LEN_W-1:0] n_q, cnt;
  logic [1:0]       pend;
  logic             pick, iss, iss_last, iss_v, kill_act;

  // token stage aligned with the RAM output
  logic             s1_v, s1_done, s1_last, s1_prog, s1_buf;
  logic [1:0]       s1_lane;
  logic             kill_s1;
  logic [7:0]       byte_sel;
  logic [39:0]      sa_shift;

  // R7: with two buffers the only waiting buffer is the later-started one,
  // so picking whichever is pending keeps start order
  assign pend     = busy_i & ~cancel_i;
  assign pick     = ~pend[0];
  assign iss      = (st == ENG_RUN);
  assign iss_last = (n_q == '0) || (cnt == n_q - 1'b1);
  assign iss_v    = iss && (n_q != '0);
  assign kill_act = (st != ENG_IDLE) && cancel_i[act];
  assign ram_addr = {act, cnt[BUF_AW-1:2]};

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ENG_IDLE;
      act      <= 1'b0;
      act_prog <= 1'b0;
      n_q      <= '0;
      cnt      <= '0;
      s1_v     <= 1'b0;
      s1_done  <= 1'b0;
      s1_last  <= 1'b0;
      s1_prog  <= 1'b0;
      s1_buf   <= 1'b0;
      s1_lane  <= '0;
    end else begin
      s1_v    <= iss_v & ~kill_act;
      s1_done <= iss & iss_last & ~kill_act;
      s1_last <= iss_last;
      s1_prog <= act_prog;
      s1_buf  <= act;
      s1_lane <= cnt[1:0];
      unique case (st)
        ENG_IDLE: if (|pend) begin
          act      <= pick;
          act_prog <= prog_i[pick];
          n_q      <= prog_i[pick] ? LEN_W'(STATION_BYTES) : len_i[pick];
          cnt      <= '0;
          st       <= ENG_RUN;
        end
        ENG_RUN: begin
          if (kill_act) st <= ENG_IDLE;
          else if (iss_last) st <= ENG_WAIT;
          else cnt <= cnt + 1'b1;
        end
        ENG_WAIT: st <= ENG_IDLE;
        default:  st <= ENG_IDLE;
      endcase
    end
  end

  assign kill_s1  = cancel_i[s1_buf];
  assign byte_sel = ram_rdata[{s1_lane, 3'b000} +: 8];
  assign done_o   = {s1_buf, ~s1_buf} & {2{s1_done & ~kill_s1}};

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_data      <= '0;
      tx_valid     <= 1'b0;
      tx_last      <= 1'b0;
      tx_irq       <= 1'b0;
      sa_shift     <= '0;
      station_addr <= '0;
    end else begin
      tx_valid <= s1_v & ~s1_prog & ~kill_s1;
      tx_last  <= s1_v & ~s1_prog & s1_last & ~kill_s1;
      tx_irq   <= s1_done & ~kill_s1 & ie_i[s1_buf];
      if (s1_v & ~s1_prog) tx_data <= byte_sel;
      if (s1_v & s1_prog & ~kill_s1) begin
        sa_shift <= {sa_shift[31:0], byte_sel};
        if (s1_done) station_addr <= {sa_shift, byte_sel};
      end
    end
  end

  p_last_needs_valid_r3: assert property (@(posedge clk) disable iff (rst)
    tx_last |-> tx_valid);
  p_idle_quiet_r3: assert property (@(posedge clk) disable iff (rst)
    (st == ENG_IDLE) |=> !tx_valid);
  p_irq_after_done_r6: assert property (@(posedge clk) disable iff (rst)
    tx_irq |-> $past(|done_o));
  p_irq_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    tx_irq |=> !tx_irq);
  p_cancel_to_idle_r8: assert property (@(posedge clk) disable iff (rst)
    ((st != ENG_IDLE) && cancel_i[act]) |=> (st == ENG_IDLE));
  p_station_on_done_r5: assert property (@(posedge clk) disable iff (rst)
    !$stable(station_addr) |-> $past(|done_o));
endmodule

// File: rtl/dual_txbuf.sv
module dual_txbuf
  import txb_pkg::*;
#(
  parameter int unsigned BUF_AW = 11,
  parameter int unsigned LEN_W  = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            bus_sel,
  input  logic            bus_we,
  input  logic [BUF_AW:0] bus_addr,
  input  logic [31:0]     bus_wdata,
  output logic [31:0]     bus_rdata,
  output logic [7:0]      tx_data,
  output logic            tx_valid,
  output logic            tx_last,
  output logic            tx_irq,
  output logic [47:0]     station_addr
);
  localparam int unsigned RAM_AW = BUF_AW - 1;

  logic              ram_we;
  logic [RAM_AW-1:0] ram_a_addr, ram_b_addr;
  logic [31:0]       ram_a_q, ram_b_q;
  logic [1:0]        busy, prog, ie, cancel, done;
  logic [LEN_W-1:0]  len [NUM_BUFS];

  txb_ram #(.AW(RAM_AW), .DW(32)) u_ram (
    .clk     (clk),
    .a_we    (ram_we),
    .a_addr  (ram_a_addr),
    .a_wdata (bus_wdata),
    .a_rdata (ram_a_q),
    .b_addr  (ram_b_addr),
    .b_rdata (ram_b_q)
  );

  txb_regs #(.BUF_AW(BUF_AW), .LEN_W(LEN_W)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .bus_sel   (bus_sel),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .ram_we    (ram_we),
    .ram_addr  (ram_a_addr),
    .ram_rdata (ram_a_q),
    .busy_o    (busy),
    .prog_o    (prog),
    .ie_o      (ie),
    .cancel_o  (cancel),
    .len_o     (len),
    .done_i    (done)
  );

  txb_engine #(.BUF_AW(BUF_AW), .LEN_W(LEN_W)) u_eng (
    .clk          (clk),
    .rst          (rst),
    .busy_i       (busy),
    .prog_i       (prog),
    .ie_i         (ie),
    .cancel_i     (cancel),
    .len_i        (len),
    .done_o       (done),
    .ram_addr     (ram_b_addr),
    .ram_rdata    (ram_b_q),
    .tx_data      (tx_data),
    .tx_valid     (tx_valid),
    .tx_last      (tx_last),
    .tx_irq       (tx_irq),
    .station_addr (station_addr)
  );
endmodule

// File: tb/sim_dual_txbuf.sv
module sim_dual_txbuf;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_sel = 1'b0, bus_we = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [7:0]  tx_data;
  logic        tx_valid, tx_last, tx_irq;
  logic [47:0] station_addr;

  always #5 clk = ~clk;

  dual_txbuf #(.BUF_AW(11), .LEN_W(16)) u0 (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tx_data(tx_data), .tx_valid(tx_valid),
    .tx_last(tx_last), .tx_irq(tx_irq), .station_addr(station_addr)
  );

  int checks = 0, fails = 0;
  bit finished = 0;

  // stream monitor, samples 2 ns after each rising edge
  logic [7:0] cap [256];
  int cap_n = 0, last_cnt = 0, last_idx = -1, gap_cnt = 0, irq_cnt = 0;
  int irq_cyc = -1, last_cyc = -2, cyc = 0;
  bit in_frame = 0;

  always @(posedge clk) begin
    #2;
    cyc++;
    if (tx_valid) begin
      if (cap_n < 256) cap[cap_n] = tx_data;
      cap_n++;
      in_frame = 1;
      if (tx_last) begin
        last_cnt++; last_idx = cap_n - 1; last_cyc = cyc; in_frame = 0;
      end
    end else if (in_frame) gap_cnt++;
    if (tx_irq) begin irq_cnt++; irq_cyc = cyc; end
  end

  task automatic finish_up();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int b, input int s, input int n);
    return 8'((s * 37 + n * 11 + b * 101 + 3) & 255);
  endfunction

  function automatic logic [11:0] stat_a(input int b);
    return 12'(b * 2048 + 'h7FC);
  endfunction

  function automatic logic [11:0] len_a(input int b);
    return 12'(b * 2048 + 'h7F4);
  endfunction

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_we = 0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_we = 0; bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
    bus_sel = 0;
  endtask

  task automatic fill(input int b, input int s, input int nbytes);
    for (int w = 0; w < (nbytes + 3) / 4; w++) begin
      logic [31:0] word;
      for (int l = 0; l < 4; l++) word[8*l +: 8] = pat(b, s, 4 * w + l);
      wr(12'(b * 2048 + w * 4), word);
    end
  endtask

  task automatic clr_mon();
    @(negedge clk);
    cap_n = 0; last_cnt = 0; last_idx = -1; gap_cnt = 0; irq_cnt = 0;
    irq_cyc = -1; last_cyc = -2; in_frame = 0;
  endtask

  task automatic wait_idle(input int b, input string req);
    logic [31:0] d;
    int n = 0;
    do begin rd(stat_a(b), d); n++; end while (d[0] && n < 400);
    check(!d[0], req, "busy bit cleared", longint'(d[0]), 0);
    repeat (2) @(negedge clk);
  endtask

  // compare captured bytes [from, from+n) with buffer b seed s
  task automatic cmp_bytes(input int from, input int b, input int s, input int n, input string req);
    int bad = 0, first = -1;
    for (int i = 0; i < n; i++)
      if (cap[from + i] !== pat(b, s, i)) begin bad++; if (first < 0) first = i; end
    if (first < 0) first = 0;
    check(bad == 0, req, "stream byte value", longint'(cap[from + first]), longint'(pat(b, s, first)));
  endtask

  task automatic send_check(input int b, input int s, input int len, input bit ie);
    fill(b, s, len);
    wr(len_a(b), 32'(len));
    clr_mon();
    wr(stat_a(b), 32'h1 | (32'(ie) << 3));
    wait_idle(b, "R4");
    check(cap_n == len, "R3", "byte count", cap_n, len);
    cmp_bytes(0, b, s, len, "R3");
    check(last_cnt == 1 && last_idx == len - 1, "R3", "last flag position", last_idx, len - 1);
    check(gap_cnt == 0, "R3", "valid gaps", gap_cnt, 0);
    check(irq_cnt == int'(ie), "R6", "irq count", irq_cnt, int'(ie));
    if (ie) check(irq_cyc == last_cyc, "R6", "irq aligned with last", irq_cyc, last_cyc);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog run did not finish actual=0 expected=1");
      finish_up();
    end
  end

  initial begin
    logic [31:0] d;
    logic [47:0] exp_sa;
    repeat (5) @(negedge clk);
    rst = 0;
    @(negedge clk);

    // R11 reset state
    check(!tx_valid && !tx_last && !tx_irq, "R11", "stream idle after reset",
          {tx_valid, tx_last, tx_irq}, 0);
    check(station_addr == 0, "R11", "station address reset", station_addr, 0);
    for (int b = 0; b < 2; b++) begin
      rd(stat_a(b), d); check(d == 0, "R11", "status reset", d, 0);
      rd(len_a(b), d);  check(d == 0, "R11", "count reset", d, 0);
    end

    // R1 address map
    wr(12'h010, 32'hDEADBEEF); wr(12'h810, 32'h01234567); wr(12'h7F0, 32'hA5A55A5A);
    rd(12'h010, d); check(d == 32'hDEADBEEF, "R1", "buffer 0 data", d, 32'hDEADBEEF);
    rd(12'h810, d); check(d == 32'h01234567, "R1", "buffer 1 data", d, 32'h01234567);
    rd(12'h7F0, d); check(d == 32'hA5A55A5A, "R1", "last data word", d, 32'hA5A55A5A);
    wr(len_a(0), 32'hABCD1234);
    rd(len_a(0), d); check(d == 32'h1234, "R1", "count width", d, 32'h1234);
    wr(12'h7F8, 32'hFFFFFFFF); wr(12'hFF8, 32'hFFFFFFFF);
    rd(12'h7F8, d); check(d == 0, "R1", "gap word 0", d, 0);
    rd(12'hFF8, d); check(d == 0, "R1", "gap word 1", d, 0);

    // R2 marker on an idle buffer has no effect
    clr_mon();
    wr(stat_a(1), 32'h80000000);
    repeat (8) @(negedge clk);
    rd(stat_a(1), d); check(d == 32'h80000000, "R2", "marker readback", d, 32'h80000000);
    check(cap_n == 0 && irq_cnt == 0, "R2", "marker caused activity", cap_n + irq_cnt, 0);

    // R5 station address load, with and without interrupt
    for (int b = 0; b < 2; b++) begin
      fill(b, 20 + b, 8);
      wr(len_a(b), 32'd3);
      clr_mon();
      wr(stat_a(b), b == 0 ? 32'hB : 32'h3);
      wait_idle(b, "R5");
      exp_sa = {pat(b, 20 + b, 0), pat(b, 20 + b, 1), pat(b, 20 + b, 2),
                pat(b, 20 + b, 3), pat(b, 20 + b, 4), pat(b, 20 + b, 5)};
      check(station_addr == exp_sa, "R5", "station address", station_addr, exp_sa);
      check(cap_n == 0, "R5", "bytes streamed on load", cap_n, 0);
      rd(stat_a(b), d);
      check(d == (b == 0 ? 32'h8 : 32'h0), "R5", "status after load", d, b == 0 ? 8 : 0);
      check(irq_cnt == (b == 0 ? 1 : 0), "R6", "irq on load", irq_cnt, b == 0 ? 1 : 0);
    end

    // R3 R4 R6 sweep over both buffers, all lane offsets
    for (int b = 0; b < 2; b++)
      for (int len = 1; len <= 9; len++)
        send_check(b, len + 3 * b, len, 1'((len + b) & 1));

    // R4 busy during a long frame
    fill(1, 30, 60); wr(len_a(1), 32'd60); clr_mon();
    wr(stat_a(1), 32'h1);
    repeat (10) @(negedge clk);
    rd(stat_a(1), d); check(d[0] == 1'b1, "R4", "busy mid-frame", d[0], 1);
    wait_idle(1, "R4");
    check(cap_n == 60, "R4", "long frame count", cap_n, 60);
    cmp_bytes(0, 1, 30, 60, "R4");

    // R7 start order, both directions
    for (int first = 0; first < 2; first++) begin
      fill(first, 40, 20); fill(1 - first, 41, 7);
      wr(len_a(first), 32'd20); wr(len_a(1 - first), 32'd7);
      clr_mon();
      wr(stat_a(first), 32'h1); wr(stat_a(1 - first), 32'h1);
      wait_idle(first, "R7"); wait_idle(1 - first, "R7");
      check(cap_n == 27 && last_cnt == 2, "R7", "two frames sent", cap_n, 27);
      cmp_bytes(0, first, 40, 20, "R7");
      cmp_bytes(20, 1 - first, 41, 7, "R7");
    end

    // R8 cancel an active frame
    fill(0, 9, 40); wr(len_a(0), 32'd40); clr_mon();
    wr(stat_a(0), 32'h9);
    repeat (8) @(negedge clk);
    wr(stat_a(0), 32'h0);
    repeat (6) @(negedge clk);
    check(last_cnt == 0 && irq_cnt == 0, "R8", "last or irq after cancel", last_cnt + irq_cnt, 0);
    check(cap_n > 0 && cap_n < 40, "R8", "partial byte count", cap_n, 20);
    cmp_bytes(0, 0, 9, cap_n, "R8");
    rd(stat_a(0), d); check(d == 0, "R8", "status after cancel", d, 0);
    send_check(0, 13, 5, 1'b1);

    // R8 cancel a waiting buffer
    fill(0, 10, 30); fill(1, 11, 4);
    wr(len_a(0), 32'd30); wr(len_a(1), 32'd4);
    clr_mon();
    wr(stat_a(0), 32'h1); wr(stat_a(1), 32'h1); wr(stat_a(1), 32'h0);
    wait_idle(0, "R8");
    repeat (6) @(negedge clk);
    check(cap_n == 30 && last_cnt == 1, "R8", "cancelled buffer sent", cap_n, 30);
    rd(stat_a(1), d); check(d == 0, "R8", "waiting buffer status", d, 0);

    // R9 zero length
    wr(len_a(1), 32'd0); clr_mon();
    wr(stat_a(1), 32'h9);
    wait_idle(1, "R9");
    check(cap_n == 0 && last_cnt == 0, "R9", "bytes for zero length", cap_n, 0);
    check(irq_cnt == 1, "R9", "completion irq", irq_cnt, 1);

    // R10 R2 rewrite while busy
    exp_sa = station_addr;
    fill(0, 12, 30); wr(len_a(0), 32'd30); clr_mon();
    wr(stat_a(0), 32'h1);
    repeat (4) @(negedge clk);
    wr(stat_a(0), 32'h8000000B);
    wait_idle(0, "R10");
    check(cap_n == 30 && last_cnt == 1 && gap_cnt == 0, "R10", "frame not restarted", cap_n, 30);
    cmp_bytes(0, 0, 12, 30, "R10");
    check(station_addr == exp_sa, "R10", "load bit ignored while busy", station_addr, exp_sa);
    check(irq_cnt == 1, "R10", "late enable irq", irq_cnt, 1);
    rd(stat_a(0), d); check(d == 32'h80000008, "R2", "marker and enable kept", d, 32'h80000008);

    finish_up();
  end
endmodule